// File: doc/BRIEF.md
# Programmable Clock Post-Divider and Output Router

This block is the digital back end of a small programmable clock generator. It sees two slow source clocks, a reference and a PLL output, as levels sampled by a fast system clock. From them it builds two clock outputs. The main output is either the PLL clock divided by 2*P, the reference itself, or the reference divided by 2*P. The secondary output is the reference, half the reference, the main output, or half the main output.

Two configuration banks each hold a post-divide value P, an input divider value R, a feedback value M, a main-source select and a secondary-source select. R and M are not used here; the active bank's values are passed out to the analog loop.

A single multi-function pin has one of four roles, chosen by a global mode field. It can be an output-enable input, a power-down input, a bank-select input, or an output that carries the secondary clock. Every divider toggles its output once every P rising edges of its source, so its duty cycle is exactly 50%.

Top module: `clk_route_div`

## Requirements
- R1: With main select 0 or 3, `clk0_out` is the PLL clock divided by 2*P. It toggles on every P-th PLL rising edge, so the high and low phases each last P source periods. A P of 0 behaves as 1.
- R2: With main select 1, `clk0_out` follows the reference level, one system clock behind the input. With main select 2, it is the reference divided by 2*P, with P of 0 treated as 1.
- R3: With pin mode 3 (clock output), `pin_oe` is 1 and `pin_out` carries the secondary source. The secondary select chooses it: 0 is the reference level, 1 toggles on every reference rising edge, 2 is `clk0_out`, and 3 toggles on every rising edge of `clk0_out`. In every other pin mode, `pin_oe` and `pin_out` are 0.
- R4: With pin mode 0 (output enable), a low pin takes `clk0_en` to 0 two system clocks later (synchronizer), and a high pin sets it back to 1. The dividers keep counting while the output is disabled.
- R5: With pin mode 1 (power-down), a low pin takes `clk0_en`, `clk0_out` and `pin_oe` to 0 and holds every divider counter and toggle stage at zero. After the pin returns high, each divider first toggles on its P-th source rising edge.
- R6: With pin mode 2 (bank select), the synchronized pin level picks the bank: 0 is bank 0 and 1 is bank 1. The change takes effect only at the edge where the reference divider reaches its terminal count. `r_out` and `m_out` always show the R and M of the active bank.
- R7: In every pin mode other than 2, the target bank is bank 1. A move to it happens at the next reference terminal count, or at once during power-down.
- R8: After reset, bank 1 is active, all dividers and toggle stages are 0, and the pin synchronizer reads 1, so the outputs are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock level |
| pll_clk | input | 1 | PLL clock level |
| pin_mode | input | 2 | Pin role: 0 enable, 1 power-down, 2 bank select, 3 clock out |
| b0_p | input | PW | Bank 0 post-divide value |
| b0_r | input | RW | Bank 0 input divider value |
| b0_m | input | MW | Bank 0 feedback value |
| b0_main_sel | input | 2 | Bank 0 main source select |
| b0_sec_sel | input | 2 | Bank 0 secondary source select |
| b1_p | input | PW | Bank 1 post-divide value |
| b1_r | input | RW | Bank 1 input divider value |
| b1_m | input | MW | Bank 1 feedback value |
| b1_main_sel | input | 2 | Bank 1 main source select |
| b1_sec_sel | input | 2 | Bank 1 secondary source select |
| pin_in | input | 1 | Multi-function pin, input side |
| clk0_out | output | 1 | Main clock output |
| clk0_en | output | 1 | Main output drive enable |
| pin_out | output | 1 | Multi-function pin, output side |
| pin_oe | output | 1 | Multi-function pin drive enable |
| r_out | output | RW | Active bank input divider value |
| m_out | output | MW | Active bank feedback value |

## Verification
The bench sweeps P over 0, 1, 2, 3 and 5 against every main and secondary select. This catches a divider that stalls or runs free at P of 0, and one whose terminal count is off by one and so shifts each toggle by a source period. It also catches half-rate stages that toggle on the wrong edge.

Every divider test starts by passing through power-down while a divider is mid-count. A design that did not clear its counters would resume with a shortened first phase.

Bank switching is driven just after a terminal count and is checked on every cycle. A design that switched at once on the pin would show the new R and M several cycles early. Leaving bank-select mode while bank 0 is active checks that the design returns to bank 1 rather than holding bank 0.

// File: rtl/clk_route_div.sv
module clk_route_div #(
  parameter int PW = 14,
  parameter int RW = 5,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          pll_clk,
  input  logic [1:0]    pin_mode,
  input  logic [PW-1:0] b0_p,
  input  logic [RW-1:0] b0_r,
  input  logic [MW-1:0] b0_m,
  input  logic [1:0]    b0_main_sel,
  input  logic [1:0]    b0_sec_sel,
  input  logic [PW-1:0] b1_p,
  input  logic [RW-1:0] b1_r,
  input  logic [MW-1:0] b1_m,
  input  logic [1:0]    b1_main_sel,
  input  logic [1:0]    b1_sec_sel,
  input  logic          pin_in,
  output logic          clk0_out,
  output logic          clk0_en,
  output logic          pin_out,
  output logic          pin_oe,
  output logic [RW-1:0] r_out,
  output logic [MW-1:0] m_out
);
  localparam logic [1:0] MODE_OE   = 2'd0;
  localparam logic [1:0] MODE_PD   = 2'd1;
  localparam logic [1:0] MODE_FSEL = 2'd2;
  localparam logic [1:0] MODE_CLK1 = 2'd3;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [1:0]    pin_sync;
  logic          pin_s, pd, oe_off, bank, target;
  logic [PW-1:0] act_p, pe, pe_m1;
  logic [1:0]    main_sel, sec_sel;
  logic          ref_q, pll_q, ref_tick, pll_tick;
  logic [PW-1:0] ref_cnt, pll_cnt;
  logic          ref_div, pll_div, ref_tc, pll_tc;
  logic          ref_half, main_half, main_rise;
  logic          clk0_int, sec_int;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_sync <= 2'b11;
      ref_q    <= 1'b0;
      pll_q    <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], pin_in};
      ref_q    <= ref_clk;
      pll_q    <= pll_clk;
    end

  assign pin_s  = pin_sync[1];
  assign pd     = (pin_mode == MODE_PD) && !pin_s;
  assign oe_off = (pin_mode == MODE_OE) && !pin_s;
  assign target = (pin_mode == MODE_FSEL) ? pin_s : 1'b1;

  assign act_p    = bank ? b1_p : b0_p;
  assign pe       = (act_p == '0) ? ONE : act_p;
  assign pe_m1    = pe - ONE;
  assign main_sel = bank ? b1_main_sel : b0_main_sel;
  assign sec_sel  = bank ? b1_sec_sel : b0_sec_sel;
  assign r_out    = bank ? b1_r : b0_r;
  assign m_out    = bank ? b1_m : b0_m;

  assign ref_tick = ref_clk && !ref_q;
  assign pll_tick = pll_clk && !pll_q;
  assign ref_tc   = ref_tick && (ref_cnt >= pe_m1);
  assign pll_tc   = pll_tick && (pll_cnt >= pe_m1);

  always_comb begin
    case (main_sel)
      2'd1:    main_rise = ref_tick;
      2'd2:    main_rise = ref_tc && !ref_div;
      default: main_rise = pll_tc && !pll_div;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt   <= '0;
      pll_cnt   <= '0;
      ref_div   <= 1'b0;
      pll_div   <= 1'b0;
      ref_half  <= 1'b0;
      main_half <= 1'b0;
      bank      <= 1'b1;
    end else if (pd) begin
      ref_cnt   <= '0;
      pll_cnt   <= '0;
      ref_div   <= 1'b0;
      pll_div   <= 1'b0;
      ref_half  <= 1'b0;
      main_half <= 1'b0;
      bank      <= target;
    end else begin
      if (ref_tick) begin
        ref_half <= !ref_half;
        if (ref_tc) begin
          ref_cnt <= '0;
          ref_div <= !ref_div;
        end else begin
          ref_cnt <= ref_cnt + ONE;
        end
      end
      if (pll_tick) begin
        if (pll_tc) begin
          pll_cnt <= '0;
          pll_div <= !pll_div;
        end else begin
          pll_cnt <= pll_cnt + ONE;
        end
      end
      if (main_rise) main_half <= !main_half;
      if (ref_tc) bank <= target;
    end

  always_comb begin
    case (main_sel)
      2'd1:    clk0_int = ref_q;
      2'd2:    clk0_int = ref_div;
      default: clk0_int = pll_div;
    endcase
    case (sec_sel)
      2'd0:    sec_int = ref_q;
      2'd1:    sec_int = ref_half;
      2'd2:    sec_int = clk0_int;
      default: sec_int = main_half;
    endcase
  end

  assign clk0_out = clk0_int && !pd;
  assign clk0_en  = !pd && !oe_off;
  assign pin_oe   = (pin_mode == MODE_CLK1);
  assign pin_out  = (pin_mode == MODE_CLK1) && sec_int;
endmodule

// File: rtl/clk_route_div_chk.sv
module clk_route_div_chk #(
  parameter int PW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pin_mode,
  input logic          pin_in,
  input logic          pd,
  input logic          bank,
  input logic          ref_tick,
  input logic [PW-1:0] ref_cnt,
  input logic [PW-1:0] pll_cnt,
  input logic [PW-1:0] pe,
  input logic          clk0_out,
  input logic          clk0_en,
  input logic          pin_oe
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt < pe); // R1

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && pin_mode == 2'd0 && !$past(pin_in) && !$past(pin_in, 2)) |-> !clk0_en); // R4

  AST_PD_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> (!clk0_en && !pin_oe && !clk0_out)); // R5

  AST_PD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (ref_cnt == '0 && pll_cnt == '0)); // R5

  AST_BANK_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank) |-> $past(ref_tick || pd)); // R6
endmodule

bind clk_route_div clk_route_div_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .pin_in(pin_in),
  .pd(pd), .bank(bank), .ref_tick(ref_tick), .ref_cnt(ref_cnt),
  .pll_cnt(pll_cnt), .pe(pe), .clk0_out(clk0_out), .clk0_en(clk0_en),
  .pin_oe(pin_oe)
);

// File: tb/sim_clk_route_div.sv
`timescale 1ns/1ps
module sim_clk_route_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0, pll_clk = 1'b0, pin_in = 1'b1;
  logic [1:0] pin_mode = 2'd0;
  logic [13:0] b0_p, b1_p;
  logic [4:0] b0_r, b1_r;
  logic [7:0] b0_m, b1_m;
  logic [1:0] b0_main_sel, b0_sec_sel, b1_main_sel, b1_sec_sel;
  logic clk0_out, clk0_en, pin_out, pin_oe;
  logic [4:0] r_out;
  logic [7:0] m_out;

  clk_route_div u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk),
    .pin_mode(pin_mode), .b0_p(b0_p), .b0_r(b0_r), .b0_m(b0_m),
    .b0_main_sel(b0_main_sel), .b0_sec_sel(b0_sec_sel), .b1_p(b1_p),
    .b1_r(b1_r), .b1_m(b1_m), .b1_main_sel(b1_main_sel),
    .b1_sec_sel(b1_sec_sel), .pin_in(pin_in), .clk0_out(clk0_out),
    .clk0_en(clk0_en), .pin_out(pin_out), .pin_oe(pin_oe),
    .r_out(r_out), .m_out(m_out)
  );

  always #4 clk = !clk;

  int n_chk = 0, n_fail = 0;
  int r_rem, p_rem, ph;
  bit r_div, p_div, r_half, m_half, mbank, pend, pend_t, ref_lvl, pll_lvl, last_tc, exp_en;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pe_of(input logic [13:0] p);
    return (p == 14'd0) ? 1 : int'(p);
  endfunction

  function automatic bit e_c0();
    logic [1:0] s;
    s = mbank ? b1_main_sel : b0_main_sel;
    case (s)
      2'd1:    return ref_lvl;
      2'd2:    return r_div;
      default: return p_div;
    endcase
  endfunction

  function automatic bit e_sec();
    logic [1:0] s;
    s = mbank ? b1_sec_sel : b0_sec_sel;
    case (s)
      2'd0:    return ref_lvl;
      2'd1:    return r_half;
      2'd2:    return e_c0();
      default: return m_half;
    endcase
  endfunction

  task automatic model_clear();
    r_rem = 0; p_rem = 0; ph = 0;
    r_div = 0; p_div = 0; r_half = 0; m_half = 0;
    mbank = 1; pend = 0; ref_lvl = 0; pll_lvl = 0; last_tc = 0;
  endtask

  task automatic cyc(input bit run);
    bit nr, np, rr, pr, oc;
    int pe_now;
    if (run) begin
      nr = (ph % 4) < 2;
      np = (ph % 2) == 0;
      ph++;
    end else begin
      nr = 0; np = 0; ph = 0;
    end
    rr = nr && !ref_lvl;
    pr = np && !pll_lvl;
    pe_now = pe_of(mbank ? b1_p : b0_p);
    oc = e_c0();
    last_tc = 0;
    if (rr) begin
      r_rem++;
      if (r_rem >= pe_now) begin r_rem = 0; r_div = !r_div; last_tc = 1; end
      r_half = !r_half;
    end
    if (pr) begin
      p_rem++;
      if (p_rem >= pe_now) begin p_rem = 0; p_div = !p_div; end
    end
    ref_lvl = nr;
    pll_lvl = np;
    if (!oc && e_c0()) m_half = !m_half;
    if (last_tc && pend) begin mbank = pend_t; pend = 0; end
    ref_clk = nr;
    pll_clk = np;
    @(negedge clk);
  endtask

  task automatic chk_cycle(input string rb, input bit ck_en);
    logic [1:0] s;
    s = mbank ? b1_main_sel : b0_main_sel;
    check((s == 2'd1 || s == 2'd2) ? "R2 clk0_out" : "R1 clk0_out", clk0_out, e_c0());
    if (pin_mode == 2'd3) begin
      check("R3 pin_out", pin_out, e_sec());
      check("R3 pin_oe", pin_oe, 1);
    end else begin
      check("R3 pin_oe idle", pin_oe, 0);
    end
    check(rb, r_out, mbank ? b1_r : b0_r);
    check(rb, m_out, mbank ? b1_m : b0_m);
    if (ck_en) check("R4 clk0_en", clk0_en, exp_en);
  endtask

  task automatic pd_enter();
    pin_mode = 2'd1;
    pin_in = 1'b0;
    repeat (4) cyc(0);
    check("R5 pd clk0_en", clk0_en, 0);
    check("R5 pd clk0_out", clk0_out, 0);
    check("R5 pd pin_oe", pin_oe, 0);
    check("R7 pd bank r_out", r_out, b1_r);
  endtask

  task automatic pd_leave();
    pin_in = 1'b1;
    repeat (4) cyc(0);
    model_clear();
  endtask

  task automatic wait_tc(input string rb);
    do begin cyc(1); chk_cycle(rb, 1); end while (!last_tc);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int pv [5] = '{0, 1, 2, 3, 5};
    b1_p = 14'd3; b1_r = 5'd7;  b1_m = 8'd100; b1_main_sel = 2'd0; b1_sec_sel = 2'd0;
    b0_p = 14'd2; b0_r = 5'd21; b0_m = 8'd55;  b0_main_sel = 2'd0; b0_sec_sel = 2'd0;
    model_clear();
    exp_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset clk0_out", clk0_out, 0);
    check("R8 reset clk0_en", clk0_en, 1);
    check("R8 reset pin_oe", pin_oe, 0);
    check("R8 reset r_out", r_out, b1_r);
    check("R8 reset m_out", m_out, b1_m);

    foreach (pv[i]) begin
      for (int ms = 0; ms < 4; ms++) begin
        for (int ss = 0; ss < 4; ss++) begin
          pd_enter();
          b1_p = 14'(pv[i]);
          b1_main_sel = 2'(ms);
          b1_sec_sel = 2'(ss);
          b0_p = 14'(pv[i] + 1);
          b0_main_sel = 2'(ms + 1);
          b0_sec_sel = 2'(ss + 1);
          pd_leave();
          pin_mode = 2'd3;
          exp_en = 1;
          repeat (48) begin cyc(1); chk_cycle("R8 r/m", 1); end
        end
      end
    end

    pd_enter();
    b1_p = 14'd2; b1_main_sel = 2'd2; b1_sec_sel = 2'd0;
    pd_leave();
    pin_mode = 2'd0;
    exp_en = 1;
    repeat (12) begin cyc(1); chk_cycle("R4 r/m", 1); end
    pin_in = 1'b0;
    repeat (2) begin cyc(1); chk_cycle("R4 r/m", 0); end
    exp_en = 0;
    repeat (16) begin cyc(1); chk_cycle("R4 r/m", 1); end
    pin_in = 1'b1;
    repeat (2) begin cyc(1); chk_cycle("R4 r/m", 0); end
    exp_en = 1;
    repeat (8) begin cyc(1); chk_cycle("R4 r/m", 1); end

    pd_enter();
    b1_p = 14'd3; b0_p = 14'd2;
    b1_main_sel = 2'd2; b0_main_sel = 2'd2;
    b1_sec_sel = 2'd0; b0_sec_sel = 2'd0;
    pd_leave();
    pin_mode = 2'd2;
    exp_en = 1;
    pin_in = 1'b0; pend = 1; pend_t = 0;
    repeat (40) begin cyc(1); chk_cycle("R6 bank", 1); end
    wait_tc("R6 bank");
    pin_in = 1'b1; pend = 1; pend_t = 1;
    repeat (40) begin cyc(1); chk_cycle("R6 bank", 1); end
    wait_tc("R6 bank");
    pin_in = 1'b0; pend = 1; pend_t = 0;
    repeat (30) begin cyc(1); chk_cycle("R6 bank", 1); end
    wait_tc("R6 bank");
    pin_mode = 2'd3; pend = 1; pend_t = 1;
    repeat (40) begin cyc(1); chk_cycle("R7 bank", 1); end
    check("R7 final bank r_out", r_out, b1_r);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule